// File: doc/BRIEF.md
# Drift-Tracking Peak/Valley Bit Slicer

This block turns a stream of measured signal periods, one value per intermediate-frequency cycle, into one data bit per bit interval. It first smooths the stream with a power-of-two moving average. It then looks for strictly shaped local maxima and minima in a sliding window of eight smoothed values. The decision threshold is set halfway between the latest maximum and the latest minimum. Each smoothed value is sliced against that threshold, and the slices gathered over a bit interval are resolved by majority vote into one output bit.

The threshold is recomputed every time a maximum follows a minimum, or a minimum follows a maximum. Because of this, it moves with slow offsets in the period stream, such as those caused by carrier frequency error or transmitter drift. Bit interval boundaries come from an external strobe, normally driven by a clock-recovery stage. A smoothed value above the threshold (a longer period) slices as 1.

Top module: `drift_slicer`

## Requirements
- R1: While reset is held and after it is released, `bit_o`, `bit_stb_o`, `bit_vld_o`, `thr_o` and `thr_vld_o` are all 0 until stimulus arrives.
- R2: Each accepted input sample produces one smoothed value. That value is floor(sum of the latest 2^AVG_LOG accepted samples / 2^AVG_LOG), where samples older than reset count as 0.
- R3: Smoothed values fill an eight-entry window, M0 newest and M7 oldest. Once eight values have arrived, M2 is a minimum when M7>M6>M5>M4>M3>M2 and M2<M1<M0, all strict. It is a maximum under the same conditions with every comparison reversed.
- R4: When a minimum is found and the previous extremum was a maximum, `thr_o` becomes floor((max+min)/2). The same holds for a maximum that follows a minimum. An extremum of the same kind as the previous one only replaces the stored value of that kind and leaves `thr_o` unchanged. A sample accepted at edge k affects `thr_o` no later than edge k+2.
- R5: `thr_vld_o` is 0, with `thr_o` equal to 0, until the first alternating pair has been found. After that, `thr_vld_o` stays 1 until reset.
- R6: Each smoothed value counts as a 1-decision only when `thr_vld_o` is 1 and the value is strictly greater than the current threshold. The current threshold does not yet include any extremum that this value itself completes.
- R7: On `bit_stb_i`, a count of 1-decisions of at least DEC/2+1 gives bit 1. A count of exactly DEC/2 keeps the previous bit. Any lower count gives bit 0. The count then restarts, and a decision made in the same cycle as the strobe belongs to the new interval.
- R8: `bit_stb_o` is a single-cycle pulse on the edge after each `bit_stb_i`. `bit_o` changes only with that pulse. `bit_vld_o` is captured at the strobe from `thr_vld_o`.
- R9: When the input level drifts slowly while data keeps alternating, `thr_o` follows the drift. Its value after the drift is higher than its first valid value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| smp_vld_i | input | 1 | Period sample valid |
| smp_i | input | SMP_W | Period sample, unsigned |
| bit_stb_i | input | 1 | Closes the current bit interval |
| bit_o | output | 1 | Voted bit |
| bit_stb_o | output | 1 | Pulse: new `bit_o` |
| bit_vld_o | output | 1 | Threshold was valid when the bit was voted |
| thr_o | output | SMP_W | Current decision threshold |
| thr_vld_o | output | 1 | Threshold has been established |

## Verification
Some internal faults show up on `thr_o` within three cycles of the sample that completes an extremum pair. These are a wrongly seeded averaging history, a window that shifts in the wrong direction, and a stored extremum of the wrong kind. All three give a value that differs from the arithmetic reference. A miscounted decision tally or a mishandled tie shows up only on `bit_o` at the next bit strobe. For that reason, bit intervals with exactly six, five and seven 1-decisions are driven directly, along with a strobe that lands in the same cycle as a decision. A stuck or reset-prone valid flag shows up on `bit_vld_o` at the first strobe.

// File: rtl/ds_pkg.sv
package ds_pkg;
  typedef enum logic [1:0] {EXT_NONE, EXT_PEAK, EXT_VALLEY} ext_e;
endpackage

// File: rtl/ds_mavg.sv
module ds_mavg #(
  parameter int W   = 10,
  parameter int LOG = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         vld_i,
  input  logic [W-1:0] smp_i,
  output logic         vld_o,
  output logic [W-1:0] avg_o
);
  localparam int LEN  = 1 << LOG;
  localparam int SUMW = W + LOG;

  logic [W-1:0]    hist_q [LEN];
  logic [SUMW-1:0] sum_q, sum_d;

  assign sum_d = sum_q + SUMW'(smp_i) - SUMW'(hist_q[LEN-1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LEN; i++) hist_q[i] <= '0;
      sum_q <= '0;
      avg_o <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        hist_q[0] <= smp_i;
        for (int i = 1; i < LEN; i++) hist_q[i] <= hist_q[i-1];
        sum_q <= sum_d;
        avg_o <= sum_d[SUMW-1:LOG];
      end
    end
  end
endmodule

// File: rtl/ds_extrema.sv
module ds_extrema
  import ds_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         vld_i,
  input  logic [W-1:0] avg_i,
  output logic [W-1:0] thr_o,
  output logic         thr_vld_o
);
  localparam int WIN = 8;
  localparam int CTR = 2;

  logic [W-1:0] win_q [WIN];
  logic [3:0]   fill_q;
  logic         new_q;
  logic [W-1:0] pk_q, vl_q;
  ext_e         last_q;
  logic         is_pk, is_vl, up_run, dn_run;
  logic [W:0]   mid_pk, mid_vl;

  // older side: strictly rising (peak) or falling (valley) into the centre
  always_comb begin
    up_run = 1'b1;
    dn_run = 1'b1;
    for (int i = CTR; i < WIN-1; i++) begin
      if (!(win_q[i+1] < win_q[i])) up_run = 1'b0;
      if (!(win_q[i+1] > win_q[i])) dn_run = 1'b0;
    end
    is_pk = new_q && up_run && (win_q[CTR] > win_q[1]) && (win_q[1] > win_q[0]);
    is_vl = new_q && dn_run && (win_q[CTR] < win_q[1]) && (win_q[1] < win_q[0]);
  end

  assign mid_pk = ({1'b0, win_q[CTR]} + {1'b0, vl_q}) >> 1;
  assign mid_vl = ({1'b0, win_q[CTR]} + {1'b0, pk_q}) >> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WIN; i++) win_q[i] <= '0;
      fill_q    <= '0;
      new_q     <= 1'b0;
      pk_q      <= '0;
      vl_q      <= '0;
      last_q    <= EXT_NONE;
      thr_o     <= '0;
      thr_vld_o <= 1'b0;
    end else begin
      new_q <= vld_i && (fill_q >= 4'(WIN-1));
      if (vld_i) begin
        win_q[0] <= avg_i;
        for (int i = 1; i < WIN; i++) win_q[i] <= win_q[i-1];
        if (fill_q < 4'(WIN)) fill_q <= fill_q + 4'd1;
      end
      if (is_pk) begin
        pk_q   <= win_q[CTR];
        last_q <= EXT_PEAK;
        if (last_q == EXT_VALLEY) begin
          thr_o     <= mid_pk[W-1:0];
          thr_vld_o <= 1'b1;
        end
      end else if (is_vl) begin
        vl_q   <= win_q[CTR];
        last_q <= EXT_VALLEY;
        if (last_q == EXT_PEAK) begin
          thr_o     <= mid_vl[W-1:0];
          thr_vld_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ds_vote.sv
module ds_vote #(
  parameter int W   = 10,
  parameter int DEC = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         vld_i,
  input  logic [W-1:0] avg_i,
  input  logic [W-1:0] thr_i,
  input  logic         thr_vld_i,
  input  logic         stb_i,
  output logic         bit_o,
  output logic         bit_stb_o,
  output logic         bit_vld_o
);
  localparam int CMAX = 4 * DEC;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] MAJ_C = CW'(DEC / 2 + 1);
  localparam logic [CW-1:0] TIE_C = CW'(DEC / 2);
  localparam logic [CW-1:0] MAX_C = CW'(CMAX);
  localparam bit HAS_TIE = (DEC % 2) == 0;

  logic [CW-1:0] ones_q;
  logic          dec_one;
  logic          vote;

  assign dec_one = vld_i && thr_vld_i && (avg_i > thr_i);

  always_comb begin
    if (ones_q >= MAJ_C)                 vote = 1'b1;
    else if (HAS_TIE && ones_q == TIE_C) vote = bit_o;
    else                                 vote = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ones_q    <= '0;
      bit_o     <= 1'b0;
      bit_stb_o <= 1'b0;
      bit_vld_o <= 1'b0;
    end else begin
      bit_stb_o <= stb_i;
      if (stb_i) begin
        bit_o     <= vote;
        bit_vld_o <= thr_vld_i;
        ones_q    <= CW'(dec_one);
      end else if (dec_one && ones_q < MAX_C) begin
        ones_q <= ones_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/drift_slicer.sv
module drift_slicer #(
  parameter int SMP_W   = 10,
  parameter int AVG_LOG = 2,
  parameter int DEC     = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_vld_i,
  input  logic [SMP_W-1:0] smp_i,
  input  logic             bit_stb_i,
  output logic             bit_o,
  output logic             bit_stb_o,
  output logic             bit_vld_o,
  output logic [SMP_W-1:0] thr_o,
  output logic             thr_vld_o
);
  logic             avg_vld;
  logic [SMP_W-1:0] avg;

  ds_mavg #(.W(SMP_W), .LOG(AVG_LOG)) u_mavg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (smp_vld_i),
    .smp_i  (smp_i),
    .vld_o  (avg_vld),
    .avg_o  (avg)
  );

  ds_extrema #(.W(SMP_W)) u_ext (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vld_i     (avg_vld),
    .avg_i     (avg),
    .thr_o     (thr_o),
    .thr_vld_o (thr_vld_o)
  );

  ds_vote #(.W(SMP_W), .DEC(DEC)) u_vote (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vld_i     (avg_vld),
    .avg_i     (avg),
    .thr_i     (thr_o),
    .thr_vld_i (thr_vld_o),
    .stb_i     (bit_stb_i),
    .bit_o     (bit_o),
    .bit_stb_o (bit_stb_o),
    .bit_vld_o (bit_vld_o)
  );
endmodule

// File: rtl/drift_slicer_chk.sv
module drift_slicer_chk #(
  parameter int SMP_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             smp_vld_i,
  input logic             bit_stb_i,
  input logic             bit_o,
  input logic             bit_stb_o,
  input logic             bit_vld_o,
  input logic [SMP_W-1:0] thr_o,
  input logic             thr_vld_o
);
  AST_STB_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_stb_i |=> bit_stb_o); // R8
  AST_NO_STRAY_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_stb_i |=> !bit_stb_o); // R8
  AST_BIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_stb_o |-> $stable(bit_o)); // R8
  AST_BIT_VLD_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_stb_o |-> bit_vld_o == $past(thr_vld_o)); // R8
  AST_THR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_vld_o |=> thr_vld_o); // R5
  AST_THR_ZERO_INVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !thr_vld_o |-> thr_o == '0); // R5
  AST_THR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(smp_vld_i) && !$past(smp_vld_i, 2) && !$past(smp_vld_i, 3))
      |-> $stable(thr_o)); // R4
endmodule

bind drift_slicer drift_slicer_chk #(.SMP_W(SMP_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .smp_vld_i (smp_vld_i),
  .bit_stb_i (bit_stb_i),
  .bit_o     (bit_o),
  .bit_stb_o (bit_stb_o),
  .bit_vld_o (bit_vld_o),
  .thr_o     (thr_o),
  .thr_vld_o (thr_vld_o)
);

// File: tb/drift_slicer_test.sv
module drift_slicer_test;
  localparam int SW  = 10;
  localparam int AL  = 2;
  localparam int DEC = 12;
  localparam int LEN = 1 << AL;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          smp_vld = 1'b0;
  logic          stb = 1'b0;
  logic [SW-1:0] smp = '0;
  logic          bit_o, bit_stb_o, bit_vld_o, thr_vld_o;
  logic [SW-1:0] thr_o;

  drift_slicer #(.SMP_W(SW), .AVG_LOG(AL), .DEC(DEC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .smp_vld_i(smp_vld), .smp_i(smp),
    .bit_stb_i(stb), .bit_o(bit_o), .bit_stb_o(bit_stb_o),
    .bit_vld_o(bit_vld_o), .thr_o(thr_o), .thr_vld_o(thr_vld_o));

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  int xh [LEN];
  int win [8];
  int wcnt = 0, mpk = 0, mvl = 0, mthr = 0, mvld = 0, mlast = 0;
  int ones = 0, mbit = 0, mbvld = 0;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic void model_sample(int x);
    int sum = 0, avg, up = 1, dn = 1;
    for (int i = LEN-1; i > 0; i--) xh[i] = xh[i-1];
    xh[0] = x;
    for (int i = 0; i < LEN; i++) sum += xh[i];
    avg = sum / LEN;                                   // R2
    if (mvld != 0 && avg > mthr) ones++;               // R6
    for (int i = 7; i > 0; i--) win[i] = win[i-1];
    win[0] = avg;
    if (wcnt < 8) wcnt++;
    if (wcnt == 8) begin                               // R3
      for (int k = 2; k < 7; k++) begin
        if (!(win[k+1] < win[k])) up = 0;
        if (!(win[k+1] > win[k])) dn = 0;
      end
      if (up != 0 && win[2] > win[1] && win[1] > win[0]) begin
        mpk = win[2];
        if (mlast == 2) begin mthr = (mpk + mvl) / 2; mvld = 1; end
        mlast = 1;
      end else if (dn != 0 && win[2] < win[1] && win[1] < win[0]) begin
        mvl = win[2];
        if (mlast == 1) begin mthr = (mpk + mvl) / 2; mvld = 1; end
        mlast = 2;
      end
    end
  endfunction

  function automatic void model_strobe();              // R7
    if (ones >= DEC/2 + 1) mbit = 1;
    else if (ones != DEC/2) mbit = 0;
    mbvld = mvld;
    ones = 0;
  endfunction

  task automatic put(int x, bit with_stb = 0);
    @(negedge clk); smp_vld = 1'b1; smp = x[SW-1:0];
    @(negedge clk); smp_vld = 1'b0;
    if (with_stb) begin stb = 1'b1; model_strobe(); end
    model_sample(x);
    @(negedge clk); stb = 1'b0;
    @(negedge clk);
    check("R3/R4 threshold value", int'(thr_o), mthr);
    check("R5 threshold valid", int'(thr_vld_o), mvld);
    if (with_stb) begin
      check("R7 strobe with decision, bit", int'(bit_o), mbit);
      check("R8 strobe with decision, vld", int'(bit_vld_o), mbvld);
    end
  endtask

  task automatic strobe();
    @(negedge clk); stb = 1'b1;
    @(negedge clk); stb = 1'b0;
    model_strobe();
    check("R8 strobe pulse", int'(bit_stb_o), 1);
    check("R6/R7 voted bit", int'(bit_o), mbit);
    check("R8 bit valid", int'(bit_vld_o), mbvld);
    @(negedge clk);
    check("R8 pulse single cycle", int'(bit_stb_o), 0);
  endtask

  function automatic int shp(int j);
    return (j <= 6) ? j : 11 - j;
  endfunction

  initial begin
    int thr_first = -1;
    logic [23:0] pat = 24'b1010_1100_1010_0101_1011_0100;
    for (int i = 0; i < LEN; i++) xh[i] = 0;
    for (int i = 0; i < 8; i++) win[i] = 0;
    repeat (3) @(negedge clk);
    check("R1 reset bit_o", int'(bit_o), 0);
    check("R1 reset bit_stb_o", int'(bit_stb_o), 0);
    check("R1 reset thr_o", int'(thr_o), 0);
    check("R1 reset thr_vld_o", int'(thr_vld_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after release bit_vld_o", int'(bit_vld_o), 0);
    strobe();                                          // R5: no threshold yet
    check("R5 bit invalid before pair", int'(bit_vld_o), 0);

    // alternating humps on a slowly rising level
    for (int b = 0; b < 24; b++) begin
      for (int j = 0; j < 12; j++) begin
        put(400 + 2*b + (pat[b] ? 10 : -10) * shp(j));
        if (thr_first < 0 && thr_vld_o) thr_first = int'(thr_o);
      end
      strobe();
    end
    check("R5 threshold established", int'(thr_vld_o), 1);
    check("R9 threshold follows drift", int'(int'(thr_o) > thr_first), 1);

    // directed vote counts on plateaus
    for (int i = 0; i < 12; i++) put(200);
    strobe();
    check("R7 all low gives 0", int'(bit_o), 0);
    for (int i = 0; i < 3; i++) put(700);
    strobe();
    check("R7 ramp interval gives 0", int'(bit_o), 0);
    for (int i = 0; i < 6; i++) put(700);
    strobe();
    check("R7 tie keeps previous 0", int'(bit_o), 0);
    for (int i = 0; i < 7; i++) put(700);
    strobe();
    check("R7 seven of twelve gives 1", int'(bit_o), 1);
    for (int i = 0; i < 6; i++) put(700);
    strobe();
    check("R7 tie keeps previous 1", int'(bit_o), 1);
    for (int i = 0; i < 5; i++) put(700);
    strobe();
    check("R7 five gives 0", int'(bit_o), 0);
    for (int i = 0; i < 6; i++) put(700);
    put(700, 1'b1);
    check("R7 tie at strobe with decision", int'(bit_o), 0);
    for (int i = 0; i < 6; i++) put(700);
    strobe();
    check("R7 same-cycle decision joins new interval", int'(bit_o), 1);
    check("R6 threshold unchanged by plateaus", int'(thr_vld_o), 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule